// File: doc/BRIEF.md
# Three-Mode Local Interrupt Timer

This block is the local timer of one processor core. It raises an interrupt request that carries an 8-bit vector. It runs in one of three modes. In one-shot mode it counts a programmed number of prescaled bus-clock ticks once. In periodic mode it counts that number again and again, and a minimum period keeps very short reload values from flooding the core with interrupts. In deadline mode it fires when a free-running 64-bit timestamp input reaches an absolute value that software has programmed.

Software uses a small 32-bit register port with four words: the control word (vector, mask and mode), the initial count, the current count and the divide select. A separate 64-bit port holds the deadline. The selected mode decides which registers are live, what they read back and which writes take effect. A write to the control word that changes the mode drops any timer that is armed.

Top module: `tri_mode_irq_timer`

## Requirements
- R1: The register port decodes `reg_addr` 0 as the control word, 1 as the initial count, 2 as the current count and 3 as the divide select, and `reg_rdata` shows the addressed word one clock after the address is presented. Control word layout: vector in bits 7:0, mask in bit 16, mode in bits 18:17, with all other bits reading 0. Mode 00 is one-shot, 01 is periodic, 10 is deadline and 11 is reserved (no timer runs). After reset the control word reads 0x0001_0000, and the counts, the divide select, the deadline and `irq_valid` are all 0.
- R2: While `dl_supported` is 0, bit 18 of a control word write is stored as 0. Writing mode 11 therefore stores 01, and writing mode 10 stores 00.
- R3: While `sw_enable` is 0, every control word write stores the mask bit as 1, whatever the written value.
- R4: A control word write that changes the mode cancels any armed countdown or deadline and clears the stored deadline. No interrupt from the old arming follows.
- R5: In one-shot mode, writing a nonzero initial count N with divide select d (bits 2:0, factor 2^d) raises `irq_valid` for exactly one cycle, in the cycle after the N*2^d-th rising edge that follows the write edge. The current count then reads 0 and no further interrupt follows.
- R6: Writing an initial count of 0 starts no timer, and no interrupt follows.
- R7: In periodic mode the count reloads from the initial count at each expiry. Interrupts repeat every max(N*2^d, MIN_PERIOD) cycles.
- R8: In periodic mode, when N*2^d is below MIN_PERIOD, the expiry is held back until MIN_PERIOD cycles have passed since the arming or the last expiry. One-shot mode is not clamped.
- R9: In deadline mode, initial-count writes are ignored (the initial count keeps its old value) and the current count reads 0.
- R10: In any mode other than deadline, the deadline port reads 0 and its writes are ignored.
- R11: In deadline mode, a deadline write stores the value and arms the timer if the value is nonzero. The timer fires at the first rising edge at which `tsc` is at or above the deadline, and `irq_valid` is high in the following cycle. A deadline already at or below `tsc` fires at the first edge after the write. A value of 0 leaves the timer disarmed.
- R12: When the deadline fires, the deadline register clears to 0 and no further interrupt comes until the deadline is written again.
- R13: When the mask bit is set, an expiry raises no `irq_valid`. When `irq_valid` is high, `irq_vector` carries the vector from the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| dl_supported | input | 1 | Deadline mode may be selected |
| sw_enable | input | 1 | Unit enabled by software; when low, control writes set the mask |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| dl_wr | input | 1 | Deadline write strobe |
| dl_wdata | input | 64 | Deadline write data |
| dl_rdata | output | 64 | Registered deadline readback |
| tsc | input | 64 | Free-running timestamp counter |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with the request |

## Verification
A wrong arming flag or count shows up at the ports as an interrupt that arrives early, arrives late, is missing, or repeats. The bench therefore samples `irq_valid` on the exact cycle that the requirements predict and on the cycle before it, and watches quiet windows after cancels, zero writes and masked expiries. A deadline or count register that holds stale state shows on the readback ports one cycle after it is sampled, so the bench reads those ports after every change of mode and after every firing.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_DEADLINE = 2'b10,
    MODE_RSVD     = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_INIT = 2'd1,
    ADDR_CUR  = 2'd2,
    ADDR_DIV  = 2'd3
  } reg_addr_e;

  localparam int CTRL_MASK_BIT = 16;
  localparam int CTRL_MODE_LO  = 17;
  localparam int VEC_W         = 8;
endpackage

// File: rtl/tmt_ctrl_reg.sv
module tmt_ctrl_reg
  import tmt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_vector,
  input  logic             wr_mask,
  input  logic [1:0]       wr_mode,
  input  logic             dl_supported,
  input  logic             sw_enable,
  output logic [VEC_W-1:0] vector,
  output logic             masked,
  output tmr_mode_e        mode,
  output logic             mode_change,
  output logic [DATA_W-1:0] rd_word
);
  tmr_mode_e  next_mode;
  logic       next_mask;

  // Bit 18 of the mode is only writable when deadline mode is supported
  assign next_mode   = tmr_mode_e'({wr_mode[1] & dl_supported, wr_mode[0]});
  assign next_mask   = wr_mask | ~sw_enable;
  assign mode_change = wr_en && (next_mode != mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      vector <= '0;
      masked <= 1'b1;
      mode   <= MODE_ONESHOT;
    end else if (wr_en) begin
      vector <= wr_vector;
      masked <= next_mask;
      mode   <= next_mode;
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[VEC_W-1:0]                    = vector;
    rd_word[CTRL_MASK_BIT]                = masked;
    rd_word[CTRL_MODE_LO+1:CTRL_MODE_LO]  = mode;
  end

  p_mode_hi_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !dl_supported) |=> (mode[1] == 1'b0))
    else $error("R2: mode bit 18 stored while deadline unsupported");

  p_sw_off_masks_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sw_enable) |=> masked)
    else $error("R3: mask not forced while software-disabled");
endmodule

// File: rtl/tmt_countdown.sv
module tmt_countdown
  import tmt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int DIV_SEL_W  = 3,
  parameter int MIN_PERIOD = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tmr_mode_e            mode,
  input  logic                 cancel,
  input  logic                 init_wr,
  input  logic [CNT_W-1:0]     init_wdata,
  input  logic                 div_wr,
  input  logic [DIV_SEL_W-1:0] div_wdata,
  output logic [CNT_W-1:0]     init_q,
  output logic [CNT_W-1:0]     cnt_q,
  output logic [DIV_SEL_W-1:0] div_q,
  output logic                 armed,
  output logic                 fire
);
  localparam int PRE_W  = (1 << DIV_SEL_W) - 1;
  localparam int PRE_W1 = PRE_W + 1;
  localparam int GAP_W  = $clog2(MIN_PERIOD) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_PERIOD - 1);

  logic [PRE_W-1:0] presc_q;
  logic [PRE_W:0]   pow;
  logic [PRE_W-1:0] lim;
  logic [GAP_W-1:0] gap_q;
  logic             live, init_take, tick, cnt_hit, gap_ok, expire;

  assign live      = (mode == MODE_ONESHOT) || (mode == MODE_PERIODIC);
  assign init_take = init_wr && (mode != MODE_DEADLINE);
  assign pow       = PRE_W1'(1) << div_q;
  assign lim       = PRE_W'(pow - 1'b1);
  assign tick      = armed && (presc_q >= lim) && (cnt_q != '0);
  assign cnt_hit   = armed && ((tick && cnt_q == CNT_W'(1)) || cnt_q == '0);
  // Periodic expiries wait until the minimum period has elapsed
  assign gap_ok    = (mode != MODE_PERIODIC) || (gap_q >= GAP_MAX);
  assign expire    = cnt_hit && gap_ok;
  assign fire      = expire && !cancel && !init_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q  <= '0;
      cnt_q   <= '0;
      div_q   <= '0;
      presc_q <= '0;
      gap_q   <= '0;
      armed   <= 1'b0;
    end else begin
      if (div_wr) div_q <= div_wdata;
      if (armed && gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;

      if (cancel) begin
        armed <= 1'b0;
      end else if (init_take) begin
        init_q  <= init_wdata;
        cnt_q   <= init_wdata;
        presc_q <= '0;
        gap_q   <= '0;
        armed   <= (init_wdata != '0) && live;
      end else if (fire) begin
        presc_q <= '0;
        if (mode == MODE_PERIODIC) begin
          cnt_q <= init_q;
          gap_q <= '0;
        end else begin
          cnt_q <= '0;
          armed <= 1'b0;
        end
      end else if (tick) begin
        presc_q <= '0;
        cnt_q   <= cnt_q - 1'b1;
      end else if (armed && cnt_q != '0) begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  p_cnt_within_init_r5: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt_q <= init_q))
    else $error("R5: running count above initial count");

  p_oneshot_stops_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && mode == MODE_ONESHOT) |=> (!armed && cnt_q == '0))
    else $error("R5: one-shot kept running after expiry");

  p_zero_init_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (init_take && !cancel && init_wdata == '0) |=> !armed)
    else $error("R6: zero initial count armed the timer");

  p_periodic_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && mode == MODE_PERIODIC) |=> (armed && cnt_q == $past(init_q)))
    else $error("R7: periodic expiry did not reload");
endmodule

// File: rtl/tmt_deadline.sv
module tmt_deadline
  import tmt_pkg::*;
#(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  tmr_mode_e       mode,
  input  logic            cancel,
  input  logic            wr,
  input  logic [TS_W-1:0] wdata,
  input  logic [TS_W-1:0] tsc,
  output logic [TS_W-1:0] rd_word,
  output logic            armed,
  output logic            fire
);
  logic [TS_W-1:0] dl_q;
  logic            live, take;

  assign live    = (mode == MODE_DEADLINE);
  assign take    = wr && live;
  // A new deadline write supersedes an expiry in the same cycle
  assign fire    = armed && (tsc >= dl_q) && !cancel && !take;
  assign rd_word = live ? dl_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dl_q  <= '0;
      armed <= 1'b0;
    end else if (cancel) begin
      dl_q  <= '0;
      armed <= 1'b0;
    end else if (take) begin
      dl_q  <= wdata;
      armed <= (wdata != '0);
    end else if (fire) begin
      dl_q  <= '0;
      armed <= 1'b0;
    end
  end

  p_fire_clears_r12: assert property (@(posedge clk) disable iff (rst)
    fire |=> (!armed && dl_q == '0))
    else $error("R12: deadline not cleared after firing");

  p_idle_outside_r10: assert property (@(posedge clk) disable iff (rst)
    !live |-> !armed)
    else $error("R10: deadline armed outside deadline mode");

  p_zero_disarms_r11: assert property (@(posedge clk) disable iff (rst)
    (take && !cancel && wdata == '0) |=> !armed)
    else $error("R11: zero deadline left timer armed");
endmodule

// File: rtl/tri_mode_irq_timer.sv
module tri_mode_irq_timer
  import tmt_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DIV_SEL_W  = 3,
  parameter int MIN_PERIOD = 16,
  parameter int TS_W       = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dl_supported,
  input  logic              sw_enable,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dl_wr,
  input  logic [TS_W-1:0]   dl_wdata,
  output logic [TS_W-1:0]   dl_rdata,
  input  logic [TS_W-1:0]   tsc,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam int CNT_W = DATA_W;

  logic              ctrl_wr, init_wr, div_wr, mode_change, masked;
  logic [VEC_W-1:0]  vector;
  tmr_mode_e         mode;
  logic [DATA_W-1:0] ctrl_word;
  logic [CNT_W-1:0]  init_q, cnt_q;
  logic [DIV_SEL_W-1:0] div_q;
  logic              cd_armed, cd_fire, dl_armed, dl_fire;
  logic [TS_W-1:0]   dl_word;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign init_wr = reg_wr && (reg_addr == ADDR_INIT);
  assign div_wr  = reg_wr && (reg_addr == ADDR_DIV);

  tmt_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(ctrl_wr),
    .wr_vector(reg_wdata[VEC_W-1:0]),
    .wr_mask(reg_wdata[CTRL_MASK_BIT]),
    .wr_mode(reg_wdata[CTRL_MODE_LO+1:CTRL_MODE_LO]),
    .dl_supported(dl_supported), .sw_enable(sw_enable),
    .vector(vector), .masked(masked), .mode(mode),
    .mode_change(mode_change), .rd_word(ctrl_word)
  );

  tmt_countdown #(.CNT_W(CNT_W), .DIV_SEL_W(DIV_SEL_W), .MIN_PERIOD(MIN_PERIOD)) u_cd (
    .clk(clk), .rst(rst), .mode(mode), .cancel(mode_change),
    .init_wr(init_wr), .init_wdata(reg_wdata),
    .div_wr(div_wr), .div_wdata(reg_wdata[DIV_SEL_W-1:0]),
    .init_q(init_q), .cnt_q(cnt_q), .div_q(div_q),
    .armed(cd_armed), .fire(cd_fire)
  );

  tmt_deadline #(.TS_W(TS_W)) u_dl (
    .clk(clk), .rst(rst), .mode(mode), .cancel(mode_change),
    .wr(dl_wr), .wdata(dl_wdata), .tsc(tsc),
    .rd_word(dl_word), .armed(dl_armed), .fire(dl_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      reg_rdata  <= '0;
      dl_rdata   <= '0;
    end else begin
      irq_valid  <= (cd_fire || dl_fire) && !masked;
      irq_vector <= vector;
      dl_rdata   <= dl_word;
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= ctrl_word;
        ADDR_INIT: reg_rdata <= init_q;
        ADDR_CUR:  reg_rdata <= (mode == MODE_DEADLINE) ? '0 : cnt_q;
        default:   reg_rdata <= DATA_W'(div_q);
      endcase
    end
  end

  p_switch_cancels_r4: assert property (@(posedge clk) disable iff (rst)
    mode_change |=> (!cd_armed && !dl_armed))
    else $error("R4: mode switch left a timer armed");

  p_masked_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !$past(masked))
    else $error("R13: interrupt raised while masked");

  p_one_source_r1: assert property (@(posedge clk) disable iff (rst)
    !(cd_fire && dl_fire))
    else $error("R1: countdown and deadline fired together");
endmodule

// File: tb/tb_tri_mode_irq_timer.sv
module tb_tri_mode_irq_timer;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_P = 16;

  logic        clk = 1'b0;
  logic        rst, dl_supported, sw_enable, reg_wr, dl_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [63:0] dl_wdata, dl_rdata, tsc;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] last_init = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_mode_irq_timer #(.MIN_PERIOD(MIN_P)) dut (
    .clk(clk), .rst(rst), .dl_supported(dl_supported), .sw_enable(sw_enable),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dl_wr(dl_wr), .dl_wdata(dl_wdata), .dl_rdata(dl_rdata), .tsc(tsc),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd1 && dut.reg_addr == 2'd1) begin end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wr_dl(input logic [63:0] d);
    dl_wr = 1'b1; dl_wdata = d;
    @(negedge clk);
    dl_wr = 1'b0;
  endtask

  task automatic expect_quiet(input int n, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_valid) seen = 1'b1;
    end
    chk(!seen, tag, {63'd0, seen}, 64'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(irq_valid == 1'b0, "R1 reset irq", {63'd0, irq_valid}, 64'd0);
    rd_reg(2'd0, v); chk(v == 32'h0001_0000, "R1 reset ctrl", v, 64'h10000);
    rd_reg(2'd2, v); chk(v == 32'd0, "R1 reset current", v, 0);
    rd_reg(2'd3, v); chk(v == 32'd0, "R1 reset divide", v, 0);
    chk(dl_rdata == 64'd0, "R1 reset deadline", dl_rdata, 0);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] v;
    dl_supported = 1'b0;
    wr_reg(2'd0, 32'h0006_0042);
    rd_reg(2'd0, v); chk(v == 32'h0002_0042, "R2 mode 11 stored as 01", v, 64'h20042);
    wr_reg(2'd0, 32'h0004_0043);
    rd_reg(2'd0, v); chk(v == 32'h0000_0043, "R2 mode 10 stored as 00", v, 64'h43);
    sw_enable = 1'b0;
    wr_reg(2'd0, 32'h0000_0011);
    rd_reg(2'd0, v); chk(v == 32'h0001_0011, "R3 mask forced", v, 64'h10011);
    sw_enable = 1'b1; dl_supported = 1'b1;
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr_reg(2'd0, 32'h0000_0055);
    wr_reg(2'd3, 32'd1);
    wr_reg(2'd1, 32'd3); last_init = 32'd3;
    cycles(5); chk(irq_valid == 1'b0, "R5 one-shot early", {63'd0, irq_valid}, 0);
    cycles(1); chk(irq_valid == 1'b1, "R5 one-shot expiry", {63'd0, irq_valid}, 1);
    chk(irq_vector == 8'h55, "R13 vector", irq_vector, 64'h55);
    expect_quiet(20, "R5 one-shot single pulse");
    rd_reg(2'd2, v); chk(v == 32'd0, "R5 current after expiry", v, 0);
  endtask

  task automatic t_zero_init();
    logic [31:0] v;
    wr_reg(2'd1, 32'd0); last_init = 32'd0;
    expect_quiet(30, "R6 zero count quiet");
    rd_reg(2'd2, v); chk(v == 32'd0, "R6 current zero", v, 0);
  endtask

  task automatic t_periodic_long();
    wr_reg(2'd0, 32'h0002_0021);
    wr_reg(2'd3, 32'd2);
    wr_reg(2'd1, 32'd5); last_init = 32'd5;
    cycles(19); chk(irq_valid == 1'b0, "R7 periodic early", {63'd0, irq_valid}, 0);
    cycles(1);  chk(irq_valid == 1'b1, "R7 periodic first", {63'd0, irq_valid}, 1);
    cycles(19); chk(irq_valid == 1'b0, "R7 periodic gap", {63'd0, irq_valid}, 0);
    cycles(1);  chk(irq_valid == 1'b1, "R7 periodic reload", {63'd0, irq_valid}, 1);
    wr_reg(2'd1, 32'd0); last_init = 32'd0;
  endtask

  task automatic t_periodic_clamp();
    wr_reg(2'd3, 32'd1);
    wr_reg(2'd1, 32'd2); last_init = 32'd2;
    cycles(MIN_P - 1); chk(irq_valid == 1'b0, "R8 clamp holds", {63'd0, irq_valid}, 0);
    cycles(1);         chk(irq_valid == 1'b1, "R8 clamp first", {63'd0, irq_valid}, 1);
    cycles(MIN_P - 1); chk(irq_valid == 1'b0, "R8 clamp second early", {63'd0, irq_valid}, 0);
    cycles(1);         chk(irq_valid == 1'b1, "R8 clamp second", {63'd0, irq_valid}, 1);
    wr_reg(2'd1, 32'd0); last_init = 32'd0;
  endtask

  task automatic t_mode_switch();
    wr_reg(2'd0, 32'h0000_0077);
    wr_reg(2'd3, 32'd0);
    wr_reg(2'd1, 32'd10); last_init = 32'd10;
    cycles(3);
    wr_reg(2'd0, 32'h0002_0077);
    expect_quiet(40, "R4 countdown cancelled by mode switch");
  endtask

  task automatic t_deadline_basic();
    tsc = 64'd500;
    wr_reg(2'd0, 32'h0004_0099);
    wr_dl(64'd1000);
    cycles(1); chk(dl_rdata == 64'd1000, "R11 deadline readback", dl_rdata, 64'd1000);
    expect_quiet(10, "R11 before deadline");
    tsc = 64'd999;
    cycles(1); chk(irq_valid == 1'b0, "R11 one below", {63'd0, irq_valid}, 0);
    tsc = 64'd1000;
    cycles(1); chk(irq_valid == 1'b1, "R11 deadline reached", {63'd0, irq_valid}, 1);
    chk(irq_vector == 8'h99, "R13 deadline vector", irq_vector, 64'h99);
    cycles(1); chk(dl_rdata == 64'd0, "R12 deadline cleared", dl_rdata, 0);
    tsc = 64'd5000;
    expect_quiet(20, "R12 no refire");
  endtask

  task automatic t_deadline_past();
    tsc = 64'd2000;
    wr_dl(64'd5);
    cycles(1); chk(irq_valid == 1'b1, "R11 past deadline at once", {63'd0, irq_valid}, 1);
  endtask

  task automatic t_deadline_zero();
    wr_dl(64'd0);
    expect_quiet(20, "R11 zero deadline idle");
    chk(dl_rdata == 64'd0, "R11 zero readback", dl_rdata, 0);
  endtask

  task automatic t_deadline_ignores_count();
    logic [31:0] v;
    wr_reg(2'd1, 32'd33);
    rd_reg(2'd1, v); chk(v == last_init, "R9 init write ignored", v, last_init);
    rd_reg(2'd2, v); chk(v == 32'd0, "R9 current reads zero", v, 0);
    expect_quiet(80, "R9 no countdown in deadline mode");
  endtask

  task automatic t_deadline_cancel();
    tsc = 64'd0;
    wr_dl(64'd300);
    wr_reg(2'd0, 32'h0000_0099);
    tsc = 64'd400;
    expect_quiet(20, "R4 deadline cancelled by mode switch");
    chk(dl_rdata == 64'd0, "R10 reads zero in one-shot", dl_rdata, 0);
  endtask

  task automatic t_dl_ignored();
    wr_dl(64'd777);
    cycles(1); chk(dl_rdata == 64'd0, "R10 write ignored in one-shot", dl_rdata, 0);
    tsc = 64'd1000;
    wr_reg(2'd0, 32'h0004_0099);
    expect_quiet(10, "R10 ignored write did not arm");
    chk(dl_rdata == 64'd0, "R10 deadline still zero", dl_rdata, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr_reg(2'd0, 32'h0001_0012);
    wr_reg(2'd3, 32'd0);
    wr_reg(2'd1, 32'd4); last_init = 32'd4;
    expect_quiet(30, "R13 masked expiry silent");
    rd_reg(2'd2, v); chk(v == 32'd0, "R13 masked timer still expired", v, 0);
  endtask

  initial begin
    rst = 1'b1; dl_supported = 1'b1; sw_enable = 1'b1;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    dl_wr = 1'b0; dl_wdata = '0; tsc = '0;
    cycles(3);
    rst = 1'b0;
    cycles(1);
    t_reset();
    t_ctrl_fields();
    t_oneshot();
    t_zero_init();
    t_periodic_long();
    t_periodic_clamp();
    t_mode_switch();
    t_deadline_basic();
    t_deadline_past();
    t_deadline_zero();
    t_deadline_ignores_count();
    t_deadline_cancel();
    t_dl_ignored();
    t_mask();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule